// File: doc/BRIEF.md
# Dual-Queue Conversion Command Sequencer

This block holds a table of conversion command words and runs two command queues against one shared analog-to-digital converter. Each command word carries a channel number and a pause marker. Queue 1 always begins at table entry 0. Queue 2 begins at a programmable start pointer into the same table. Each queue starts from its own trigger input. For every command word it executes, the block issues one start request on a start/done converter handshake. It also reports which queue and which table entry each finished conversion belongs to.

Queue 1 has priority. If queue 1 is triggered while queue 2 is converting, the block aborts the converter, and queue 2 is held suspended at the command word it lost. When queue 1 goes idle or pauses, queue 2 resumes and runs that same command word again. For each queue the block keeps three sticky flags, which are cleared by writing 1: end reached, pause reached, and trigger overrun. A 4-bit status code gives the combined condition of both queues.

Top module: `ccw_seq`

## Requirements
- R1: Each queue executes its command words in ascending table order. Queue 1 starts at entry 0 and queue 2 starts at `q2_base_i` when triggered from idle. Each executed word produces exactly one `conv_start_o` pulse, with `conv_chan_o` equal to bits [5:0] of the word. Each accepted `conv_done_i` produces one `res_valid_o` pulse carrying the queue (`res_q_o`, 0 = queue 1) and the table index.
- R2: A queue ends when it reaches a word whose channel field is all ones, which starts no conversion, or when it completes the last table entry. At that point its end flag sets and the queue returns to idle.
- R3: When a word with bit 6 (pause) set completes, the queue's pause flag sets and the queue stops in the paused condition. Its next trigger resumes it at the following word.
- R4: A trigger that arrives while its queue is pending, active or suspended sets that queue's overrun flag. Apart from that, the trigger has no effect on the order or content of the conversions.
- R5: A queue 1 trigger that arrives while queue 2 is converting raises `conv_abort_o` for one cycle. While `conv_abort_o` is high the status code is 4'b1010. The aborted word returns no result, and queue 2 re-executes it once queue 1 is idle or paused.
- R6: `flags_o` bit 0/1 is the end flag of queue 1/2, bit 2/3 is the pause flag of queue 1/2, and bit 4/5 is the overrun flag of queue 1/2. The flags are sticky. A cycle with `flag_clr_we_i` high clears each flag whose bit in `flag_clr_i` is 1, unless that flag is being set in the same cycle, in which case it stays set.
- R7: `qs_o[3:2]` encodes queue 1 and `qs_o[1:0]` encodes queue 2: 00 idle, 01 paused, 10 active (for queue 2 this also covers suspended), 11 trigger pending.
- R8: The codes 4'b0011 and 4'b0111 each last exactly one cycle. The queue 2 pending state moves to active on the next cycle whenever queue 1 is idle or paused.
- R9: After reset both queues are idle, `qs_o` is 0, all flags are 0, and no start, abort or result pulse is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Command table write enable |
| tbl_addr_i | input | 4 | Command table write index |
| tbl_wdata_i | input | 7 | Command word: bit 6 pause, bits 5:0 channel |
| q2_base_i | input | 4 | Queue 2 start index |
| trig_i | input | 2 | Trigger pulses, bit 0 queue 1, bit 1 queue 2 |
| flag_clr_we_i | input | 1 | Flag clear strobe |
| flag_clr_i | input | 6 | Write-1-to-clear mask for the flags |
| flags_o | output | 6 | Sticky end, pause and overrun flags |
| qs_o | output | 4 | Combined queue status code |
| conv_start_o | output | 1 | Converter start pulse |
| conv_abort_o | output | 1 | Converter abort pulse |
| conv_chan_o | output | 6 | Channel of the current conversion |
| conv_done_i | input | 1 | Converter done pulse |
| res_valid_o | output | 1 | Completed conversion pulse |
| res_q_o | output | 1 | Queue of the completed conversion |
| res_idx_o | output | 4 | Table index of the completed conversion |

## Verification
The first pattern runs queue 1 alone through a pause and then an end-of-queue word, and it re-triggers queue 1 while it is running. This separates a premature trigger that only raises the overrun flag from one that restarts the queue. It also shows that the end word starts no conversion. The second pattern starts queue 2 and preempts it with queue 1 in the middle of a conversion. The start and result logs then show whether the aborted word is dropped and run again, and whether queue 2 runs to the last table entry. A final trigger of queue 2 while queue 1 is paused exposes the one-cycle transitional code.

// File: rtl/ccw_seq_pkg.sv
package ccw_seq_pkg;

  typedef enum logic [2:0] {
    Q_IDLE,
    Q_PAUSED,
    Q_ACTIVE,
    Q_PEND,
    Q_SUSP
  } qstate_e;

  localparam int NUM_FLAGS = 6;

endpackage

// File: rtl/ccw_table.sv
module ccw_table #(
  parameter int DEPTH = 16,
  parameter int W     = 7,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [W-1:0]  rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_b_o
);

  logic [W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem[g] <= '0;
      else if (we_i && (waddr_i == AW'(g)))    mem[g] <= wdata_i;
    end
  end

  assign rdata_a_o = mem[raddr_a_i];
  assign rdata_b_o = mem[raddr_b_i];

endmodule

// File: rtl/ccw_flags.sv
module ccw_flags #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    // set has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   q <= 1'b0;
      else if (set_i[g])             q <= 1'b1;
      else if (clr_we_i && clr_i[g]) q <= 1'b0;
    end
    assign flags_o[g] = q;
  end

endmodule

// File: rtl/ccw_qs_enc.sv
module ccw_qs_enc
  import ccw_seq_pkg::*;
(
  input  qstate_e    q1_i,
  input  qstate_e    q2_i,
  output logic [3:0] qs_o
);

  function automatic logic [1:0] enc(qstate_e s);
    case (s)
      Q_PAUSED:         enc = 2'b01;
      Q_ACTIVE, Q_SUSP: enc = 2'b10;
      Q_PEND:           enc = 2'b11;
      default:          enc = 2'b00;
    endcase
  endfunction

  assign qs_o = {enc(q1_i), enc(q2_i)};

endmodule

// File: rtl/ccw_seq.sv
module ccw_seq
  import ccw_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CH_W  = 6,
  localparam int AW    = $clog2(DEPTH),
  localparam int CCW_W = CH_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tbl_we_i,
  input  logic [AW-1:0]    tbl_addr_i,
  input  logic [CCW_W-1:0] tbl_wdata_i,
  input  logic [AW-1:0]    q2_base_i,
  input  logic [1:0]       trig_i,
  input  logic             flag_clr_we_i,
  input  logic [NUM_FLAGS-1:0] flag_clr_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic [3:0]       qs_o,
  output logic             conv_start_o,
  output logic             conv_abort_o,
  output logic [CH_W-1:0]  conv_chan_o,
  input  logic             conv_done_i,
  output logic             res_valid_o,
  output logic             res_q_o,
  output logic [AW-1:0]    res_idx_o
);

  localparam logic [AW-1:0]   LAST = AW'(DEPTH - 1);
  localparam logic [CH_W-1:0] EOQ  = '1;

  qstate_e s1_q, s2_q, a1, a2, n1, n2;
  logic [AW-1:0] p1_q, p2_q, pa1, pa2, pn1, pn2;
  logic busy_q, own2_q, busy_n, own_n;
  logic start_q, abort_q, start_n, abort_n;
  logic [CH_W-1:0] chan_q, chan_n;
  logic pause_q, pause_n;
  logic res_v_q, res_qq, fin;
  logic [AW-1:0] res_idx_q;
  logic [1:0] set_cf, set_pf, set_tor;
  logic [CCW_W-1:0] ccw_a, ccw_b;

  ccw_table #(.DEPTH(DEPTH), .W(CCW_W)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (tbl_we_i),
    .waddr_i   (tbl_addr_i),
    .wdata_i   (tbl_wdata_i),
    .raddr_a_i (pa1),
    .rdata_a_o (ccw_a),
    .raddr_b_i (pa2),
    .rdata_b_o (ccw_b)
  );

  always_comb begin
    a1 = s1_q;  a2 = s2_q;  pa1 = p1_q;  pa2 = p2_q;
    set_cf = '0; set_pf = '0; set_tor = '0;
    busy_n = busy_q; own_n = own2_q; fin = 1'b0;
    start_n = 1'b0; abort_n = 1'b0; chan_n = chan_q; pause_n = pause_q;

    // completion of the running word
    if (busy_q && conv_done_i) begin
      busy_n = 1'b0;
      fin    = 1'b1;
      if (!own2_q) begin
        set_pf[0] = pause_q;
        if (p1_q == LAST) begin a1 = Q_IDLE; set_cf[0] = 1'b1; end
        else begin pa1 = p1_q + AW'(1); if (pause_q) a1 = Q_PAUSED; end
      end else begin
        set_pf[1] = pause_q;
        if (p2_q == LAST) begin a2 = Q_IDLE; set_cf[1] = 1'b1; end
        else begin pa2 = p2_q + AW'(1); if (pause_q) a2 = Q_PAUSED; end
      end
    end

    // dispatch from post-completion state
    n1 = a1; n2 = a2; pn1 = pa1; pn2 = pa2;
    if (a1 == Q_PEND) begin
      n1 = Q_ACTIVE;
      if (a2 == Q_ACTIVE) begin
        n2 = Q_SUSP;
        if (busy_n) begin busy_n = 1'b0; abort_n = 1'b1; end
      end
    end else if (a1 == Q_ACTIVE) begin
      if (!busy_n) begin
        if (ccw_a[CH_W-1:0] == EOQ) begin n1 = Q_IDLE; set_cf[0] = 1'b1; end
        else begin
          busy_n = 1'b1; own_n = 1'b0; start_n = 1'b1;
          chan_n = ccw_a[CH_W-1:0]; pause_n = ccw_a[CH_W];
        end
      end
    end else if (a2 == Q_PEND || a2 == Q_SUSP) begin
      n2 = Q_ACTIVE;
    end else if (a2 == Q_ACTIVE && !busy_n) begin
      if (ccw_b[CH_W-1:0] == EOQ) begin n2 = Q_IDLE; set_cf[1] = 1'b1; end
      else begin
        busy_n = 1'b1; own_n = 1'b1; start_n = 1'b1;
        chan_n = ccw_b[CH_W-1:0]; pause_n = ccw_b[CH_W];
      end
    end

    // triggers, judged on post-completion state
    if (trig_i[0]) begin
      if (a1 == Q_IDLE || a1 == Q_PAUSED) begin
        n1 = Q_PEND;
        if (a1 == Q_IDLE) pn1 = '0;
      end else set_tor[0] = 1'b1;
    end
    if (trig_i[1]) begin
      if (a2 == Q_IDLE || a2 == Q_PAUSED) begin
        n2 = Q_PEND;
        if (a2 == Q_IDLE) pn2 = q2_base_i;
      end else set_tor[1] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= Q_IDLE;  s2_q <= Q_IDLE;
      p1_q <= '0;      p2_q <= '0;
      busy_q <= 1'b0;  own2_q <= 1'b0;
      start_q <= 1'b0; abort_q <= 1'b0;
      chan_q <= '0;    pause_q <= 1'b0;
      res_v_q <= 1'b0; res_qq <= 1'b0; res_idx_q <= '0;
    end else begin
      s1_q <= n1;      s2_q <= n2;
      p1_q <= pn1;     p2_q <= pn2;
      busy_q <= busy_n; own2_q <= own_n;
      start_q <= start_n; abort_q <= abort_n;
      chan_q <= chan_n; pause_q <= pause_n;
      res_v_q <= fin;
      if (fin) begin
        res_qq    <= own2_q;
        res_idx_q <= own2_q ? p2_q : p1_q;
      end
    end
  end

  ccw_flags #(.N(NUM_FLAGS)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    ({set_tor, set_pf, set_cf}),
    .clr_we_i (flag_clr_we_i),
    .clr_i    (flag_clr_i),
    .flags_o  (flags_o)
  );

  ccw_qs_enc u_enc (
    .q1_i (s1_q),
    .q2_i (s2_q),
    .qs_o (qs_o)
  );

  assign conv_start_o = start_q;
  assign conv_abort_o = abort_q;
  assign conv_chan_o  = chan_q;
  assign res_valid_o  = res_v_q;
  assign res_q_o      = res_qq;
  assign res_idx_o    = res_idx_q;

endmodule

// File: rtl/ccw_seq_chk.sv
module ccw_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] qs_o,
  input logic [5:0] flags_o,
  input logic       flag_clr_we_i,
  input logic       conv_abort_o
);

  p_transient_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qs_o == 4'b0011 || qs_o == 4'b0111) |=> !(qs_o == 4'b0011 || qs_o == 4'b0111));

  p_abort_suspend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_abort_o |-> (qs_o == 4'b1010));

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_clr_we_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  p_end_not_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[0]) |-> (qs_o[3:2] != 2'b10));

  p_pause_stops_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[3]) |-> (qs_o[1:0] != 2'b10));

endmodule

bind ccw_seq ccw_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .qs_o          (qs_o),
  .flags_o       (flags_o),
  .flag_clr_we_i (flag_clr_we_i),
  .conv_abort_o  (conv_abort_o)
);

// File: tb/ccw_seq_tb_top.sv
`timescale 1ns/1ps
module ccw_seq_tb_top;

  localparam int LAT = 5;

  // command table program: {pause, chan}
  localparam logic [6:0] PROG [16] = '{
    7'd5, 7'd73, 7'd12, 7'd3, 7'd63, 7'd0, 7'd0, 7'd0,
    7'd20, 7'd21, 7'd22, 7'd23, 7'd30, 7'd31, 7'd32, 7'd33
  };
  localparam int E2_IDX [4]  = '{0, 1, 2, 3};
  localparam int E4_IDX [10] = '{8, 0, 1, 9, 10, 11, 12, 13, 14, 15};
  localparam int E4_Q   [10] = '{1, 0, 0, 1, 1, 1, 1, 1, 1, 1};
  localparam int E4_SCH [11] = '{20, 21, 5, 9, 21, 22, 23, 30, 31, 32, 33};

  logic clk = 1'b0, rst_n = 1'b0;
  logic tbl_we = 1'b0;
  logic [3:0] tbl_addr = '0, q2_base = 4'd8;
  logic [6:0] tbl_wdata = '0;
  logic [1:0] trig = '0;
  logic flag_clr_we = 1'b0;
  logic [5:0] flag_clr = '0;
  logic [5:0] flags;
  logic [3:0] qs;
  logic conv_start, conv_abort, conv_done, res_valid, res_q;
  logic [5:0] conv_chan;
  logic [3:0] res_idx;

  int errs = 0, checks = 0;
  int n_res = 0, n_st = 0;
  int lq [64], li [64], sch [64];
  int stub_cnt = 0;

  always #2.5 clk = ~clk;

  ccw_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr),
    .tbl_wdata_i(tbl_wdata), .q2_base_i(q2_base), .trig_i(trig),
    .flag_clr_we_i(flag_clr_we), .flag_clr_i(flag_clr), .flags_o(flags),
    .qs_o(qs), .conv_start_o(conv_start), .conv_abort_o(conv_abort),
    .conv_chan_o(conv_chan), .conv_done_i(conv_done), .res_valid_o(res_valid),
    .res_q_o(res_q), .res_idx_o(res_idx)
  );

  // converter stub
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stub_cnt <= 0; conv_done <= 1'b0;
    end else begin
      conv_done <= 1'b0;
      if (conv_abort)          stub_cnt <= 0;
      else if (conv_start)     stub_cnt <= LAT;
      else if (stub_cnt == 1)  begin conv_done <= 1'b1; stub_cnt <= 0; end
      else if (stub_cnt != 0)  stub_cnt <= stub_cnt - 1;
    end
  end

  // logs
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) begin
        if (n_res < 64) begin lq[n_res] = int'(res_q); li[n_res] = int'(res_idx); end
        n_res++;
      end
      if (conv_start) begin
        if (n_st < 64) sch[n_st] = int'(conv_chan);
        n_st++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_trig(input int q);
    trig[q] = 1'b1;
    tick();
    trig = '0;
  endtask

  task automatic clr(input logic [5:0] m);
    flag_clr_we = 1'b1; flag_clr = m;
    tick();
    flag_clr_we = 1'b0; flag_clr = '0;
  endtask

  task automatic wait_flag(input int b, input string req);
    int k;
    k = 0;
    while (!flags[b] && k < 500) begin tick(); k++; end
    chk(req, int'(flags[b]), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int b_res, b_st;
    repeat (3) tick();
    // R9 reset state
    chk("R9 qs", int'(qs), 0);
    chk("R9 flags", int'(flags), 0);
    chk("R9 start", int'(conv_start), 0);
    chk("R9 result", int'(res_valid), 0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < 16; i++) begin
      tbl_we = 1'b1; tbl_addr = 4'(i); tbl_wdata = PROG[i];
      tick();
    end
    tbl_we = 1'b0;
    repeat (2) tick();

    // queue 1: overrun, pause, resume, end code
    b_res = n_res; b_st = n_st;
    pulse_trig(0);
    chk("R7 q1 pending", int'(qs), 4'b1100);
    tick();
    chk("R7 q1 active", int'(qs), 4'b1000);
    pulse_trig(0);
    chk("R4 overrun q1", int'(flags[4]), 1);
    trig[0] = 1'b1; flag_clr_we = 1'b1; flag_clr = 6'b010000;
    tick();
    trig = '0; flag_clr_we = 1'b0; flag_clr = '0;
    chk("R6 set wins over clear", int'(flags[4]), 1);
    clr(6'b010000);
    chk("R6 clear overrun", int'(flags), 0);
    wait_flag(2, "R3 pause flag q1");
    repeat (2) tick();
    chk("R3 paused code", int'(qs), 4'b0100);
    chk("R3 results at pause", n_res - b_res, 2);
    repeat (10) tick();
    chk("R3 holds while paused", n_st - b_st, 2);
    pulse_trig(0);
    wait_flag(0, "R2 end flag q1");
    repeat (2) tick();
    chk("R2 idle after end code", int'(qs), 0);
    chk("R2 no start for end code", n_st - b_st, 4);
    chk("R1 q1 result count", n_res - b_res, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R4 order unchanged idx", li[b_res + i], E2_IDX[i]);
      chk("R1 q1 chan", sch[b_st + i], int'(PROG[E2_IDX[i]][5:0]));
    end
    clr(6'b111111);
    chk("R6 clear all", int'(flags), 0);

    // queue 2 preempted by queue 1
    b_res = n_res; b_st = n_st;
    pulse_trig(1);
    chk("R8 transitional 0011", int'(qs), 4'b0011);
    tick();
    chk("R8 q2 active", int'(qs), 4'b0010);
    while (!(conv_start && conv_chan == 6'd21)) tick();
    pulse_trig(0);
    chk("R7 q1 pending q2 active", int'(qs), 4'b1110);
    tick();
    chk("R5 abort pulse", int'(conv_abort), 1);
    chk("R5 suspended code", int'(qs), 4'b1010);
    wait_flag(2, "R3 pause flag q1 preempt");
    wait_flag(1, "R2 end flag q2 last entry");
    repeat (2) tick();
    chk("R7 q1 paused q2 idle", int'(qs), 4'b0100);
    chk("R5 result count", n_res - b_res, 10);
    for (int i = 0; i < 10; i++) begin
      chk("R5 result idx", li[b_res + i], E4_IDX[i]);
      chk("R1 result queue", lq[b_res + i], E4_Q[i]);
    end
    chk("R5 start count", n_st - b_st, 11);
    for (int i = 0; i < 11; i++) chk("R5 start chan", sch[b_st + i], E4_SCH[i]);

    // transitional code with queue 1 paused
    clr(6'b111111);
    pulse_trig(1);
    chk("R8 transitional 0111", int'(qs), 4'b0111);
    tick();
    chk("R8 q2 leaves pending", int'(qs), 4'b0110);
    wait_flag(1, "R2 end flag q2 rerun");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule